// File: doc/BRIEF.md
# Multicycle Control Sequencer

This block is the hardwired control sequencer for a multicycle processor datapath. Each cycle it drives a fixed set of control strobes and mux selects toward the datapath: program counter update, memory access, instruction register load, ALU operand and operation choice, and register file write. Which strobes it drives depends only on its internal step. The only data input it looks at is the 6-bit primary opcode field of the instruction currently held in the instruction register.

Every instruction begins with a shared instruction-load step and a shared operand-read step. At the end of the operand-read step the sequencer picks a path by opcode. Loads take 5 cycles, stores and register-register operations take 4, and equal-branches and jumps take 3. Every path ends by going back to the instruction-load step. An opcode the sequencer does not recognise ends the instruction after the operand-read step, and no write strobe is raised. The outputs are a pure function of the current step (Moore style), so the datapath sees glitch-free selects for a full cycle.

Top module: `mc_ctrl`

## Requirements
- R1: `rst_ni` low puts the sequencer into the load step at once (asynchronously). The load-step vector is held while reset is low and in the first cycle after release.
- R2: The load step drives pc_wr=1, mem_rd=1, ir_wr=1, addr_sel=0 (PC), alu_a_sel=0 (PC), alu_b_sel=01 (constant 4), alu_op=00 (add), pc_src=00 (ALU result). It is always followed by the operand-read step.
- R3: The operand-read step drives alu_a_sel=0, alu_b_sel=11 (shifted sign-extended offset), alu_op=00. The next step is chosen by opcode: 0x23 or 0x2B go to address calculation, 0x00 goes to register execute, 0x04 goes to branch, 0x02 goes to jump, and any other value goes back to the load step.
- R4: The address step drives alu_a_sel=1 (register A), alu_b_sel=10 (sign-extended offset), alu_op=00. Opcode 0x23 then goes to memory read, 0x2B goes to memory write, and any other value goes to the load step.
- R5: A load runs read (mem_rd=1, addr_sel=1), then write-back (rf_wr=1, rf_dst=0, wb_sel=1), then the load step: 5 cycles in total.
- R6: A store runs write (mem_wr=1, addr_sel=1), then the load step: 4 cycles in total.
- R7: A register-register operation runs execute (alu_a_sel=1, alu_b_sel=00, alu_op=10 function field), then write-back (rf_wr=1, rf_dst=1, wb_sel=0), then the load step: 4 cycles in total.
- R8: A branch runs one step with alu_a_sel=1, alu_b_sel=00, alu_op=01 (subtract), pc_wr_cond=1, pc_src=01 (ALU register), then the load step.
- R9: A jump runs one step with pc_wr=1, pc_src=10 (jump target), then the load step.
- R10: The opcode is ignored in every step other than operand-read and address calculation.
- R11: Every output not listed for a step is 0 in that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Primary opcode from the instruction register |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write if the ALU zero flag is set |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| wb_sel_o | output | 1 | Register write data: 0 ALU register, 1 memory data |
| ir_wr_o | output | 1 | Instruction register load |
| pc_src_o | output | 2 | PC source: 00 ALU result, 01 ALU register, 10 jump target |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 use function field |
| alu_a_sel_o | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B: 00 register B, 01 constant 4, 10 offset, 11 offset shifted by 2 |
| rf_wr_o | output | 1 | Register file write |
| rf_dst_o | output | 1 | Destination: 0 second source field, 1 destination field |

## Verification
Each instruction class is issued alone and in back-to-back mixes. The full control vector is compared in every cycle, so a wrong path, a wrong length or a stray strobe shows up at its own cycle. Two opcodes that are not recognised separate the load-step fallback from a valid decode. A load whose opcode turns into an unknown value or into a store during address calculation shows that the second decision point really reads the opcode. A register-register operation whose opcode changes during execute shows that the opcode is ignored elsewhere. A reset in the middle of a load checks the asynchronous return to the load step.

// File: rtl/mc_ctrl_pkg.sv
`timescale 1ns/1ps
package mc_ctrl_pkg;

  localparam int unsigned ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MRD    = 4'd3,
    ST_MWR    = 4'd4,
    ST_LDWB   = 4'd5,
    ST_REXEC  = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } state_e;

  typedef enum logic [2:0] {
    CLS_LOAD,
    CLS_STORE,
    CLS_RTYPE,
    CLS_BRANCH,
    CLS_JUMP,
    CLS_NONE
  } op_class_e;

  localparam logic [1:0] PCSRC_ALU  = 2'b00;
  localparam logic [1:0] PCSRC_AREG = 2'b01;
  localparam logic [1:0] PCSRC_JMP  = 2'b10;

  localparam logic [1:0] ALUOP_ADD  = 2'b00;
  localparam logic [1:0] ALUOP_SUB  = 2'b01;
  localparam logic [1:0] ALUOP_FN   = 2'b10;

  localparam logic [1:0] BSEL_REG   = 2'b00;
  localparam logic [1:0] BSEL_FOUR  = 2'b01;
  localparam logic [1:0] BSEL_IMM   = 2'b10;
  localparam logic [1:0] BSEL_IMMSH = 2'b11;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_sel;
    logic       ir_wr;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst;
  } ctrl_t;

endpackage

// File: rtl/mc_op_classify.sv
`timescale 1ns/1ps
module mc_op_classify
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned OP_W = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
  input  logic [OP_W-1:0] opcode_i,
  output op_class_e       class_o
);

  always_comb begin
    class_o = CLS_NONE;
    if      (opcode_i == OP_LOAD)   class_o = CLS_LOAD;
    else if (opcode_i == OP_STORE)  class_o = CLS_STORE;
    else if (opcode_i == OP_RTYPE)  class_o = CLS_RTYPE;
    else if (opcode_i == OP_BRANCH) class_o = CLS_BRANCH;
    else if (opcode_i == OP_JUMP)   class_o = CLS_JUMP;
  end

endmodule

// File: rtl/mc_next_state.sv
`timescale 1ns/1ps
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e    state_i,
  input  op_class_e class_i,
  output state_e    next_o
);

  always_comb begin
    next_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:  next_o = ST_DECODE;
      ST_DECODE: begin
        unique case (class_i)
          CLS_LOAD, CLS_STORE: next_o = ST_MADDR;
          CLS_RTYPE:           next_o = ST_REXEC;
          CLS_BRANCH:          next_o = ST_BRANCH;
          CLS_JUMP:            next_o = ST_JUMP;
          default:             next_o = ST_FETCH;
        endcase
      end
      ST_MADDR: begin
        if      (class_i == CLS_LOAD)  next_o = ST_MRD;
        else if (class_i == CLS_STORE) next_o = ST_MWR;
        else                           next_o = ST_FETCH;
      end
      ST_MRD:   next_o = ST_LDWB;
      ST_REXEC: next_o = ST_RWB;
      default:  next_o = ST_FETCH;  // terminal steps and unused codes
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
`timescale 1ns/1ps
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_src    = PCSRC_ALU;
        ctrl_o.alu_op    = ALUOP_ADD;
        ctrl_o.alu_b_sel = BSEL_FOUR;
      end
      ST_DECODE: begin
        ctrl_o.alu_op    = ALUOP_ADD;
        ctrl_o.alu_b_sel = BSEL_IMMSH;  // precompute branch target
      end
      ST_MADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_IMM;
        ctrl_o.alu_op    = ALUOP_ADD;
      end
      ST_MRD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_MWR: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl_o.rf_wr  = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      ST_REXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_REG;
        ctrl_o.alu_op    = ALUOP_FN;
      end
      ST_RWB: begin
        ctrl_o.rf_wr  = 1'b1;
        ctrl_o.rf_dst = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = BSEL_REG;
        ctrl_o.alu_op     = ALUOP_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = PCSRC_AREG;
      end
      ST_JUMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = PCSRC_JMP;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned OP_W = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output logic            pc_wr_o,
  output logic            pc_wr_cond_o,
  output logic            addr_sel_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            wb_sel_o,
  output logic            ir_wr_o,
  output logic [1:0]      pc_src_o,
  output logic [1:0]      alu_op_o,
  output logic            alu_a_sel_o,
  output logic [1:0]      alu_b_sel_o,
  output logic            rf_wr_o,
  output logic            rf_dst_o
);

  state_e    state_q, state_d;
  op_class_e op_class;
  ctrl_t     ctrl;

  mc_op_classify #(
    .OP_W     (OP_W),
    .OP_RTYPE (OP_RTYPE),
    .OP_LOAD  (OP_LOAD),
    .OP_STORE (OP_STORE),
    .OP_BRANCH(OP_BRANCH),
    .OP_JUMP  (OP_JUMP)
  ) u_classify (
    .opcode_i(opcode_i),
    .class_o (op_class)
  );

  mc_next_state u_next (
    .state_i(state_q),
    .class_i(op_class),
    .next_o (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  mc_ctrl_decode u_decode (
    .state_i(state_q),
    .ctrl_o (ctrl)
  );

  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign wb_sel_o     = ctrl.wb_sel;
  assign ir_wr_o      = ctrl.ir_wr;
  assign pc_src_o     = ctrl.pc_src;
  assign alu_op_o     = ctrl.alu_op;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign rf_wr_o      = ctrl.rf_wr;
  assign rf_dst_o     = ctrl.rf_dst;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R2

  AST_LOAD_STEP_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |-> (ir_wr_o && mem_rd_o && pc_wr_o && !addr_sel_o)); // R2

  AST_ADDR_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MADDR) |=> (state_q inside {ST_MRD, ST_MWR, ST_FETCH})); // R4

  AST_LOAD_READ_TO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MRD) |=> (state_q == ST_LDWB && wb_sel_o && rf_wr_o)); // R5

  AST_STORE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (state_q == ST_FETCH)); // R6

  AST_EXEC_TO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REXEC) |=> (rf_wr_o && rf_dst_o)); // R7

  AST_PC_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pc_wr_o && pc_wr_cond_o)); // R8

  AST_MEM_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11

  AST_TERMINAL_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_LDWB, ST_RWB, ST_BRANCH, ST_JUMP}) |=> (state_q == ST_FETCH)); // R9

  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE && op_class == CLS_NONE) |=> (state_q == ST_FETCH)); // R3

endmodule

// File: tb/mc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h3F;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_sel, ir_wr;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic       alu_a_sel, rf_wr, rf_dst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode),
    .pc_wr_o(pc_wr), .pc_wr_cond_o(pc_wr_cond), .addr_sel_o(addr_sel),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .wb_sel_o(wb_sel), .ir_wr_o(ir_wr),
    .pc_src_o(pc_src), .alu_op_o(alu_op), .alu_a_sel_o(alu_a_sel),
    .alu_b_sel_o(alu_b_sel), .rf_wr_o(rf_wr), .rf_dst_o(rf_dst)
  );

  // {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,wb_sel,ir_wr,pc_src,alu_op,alu_a_sel,alu_b_sel,rf_wr,rf_dst}
  localparam logic [15:0] V_FETCH = {7'b1001001, 2'b00, 2'b00, 1'b0, 2'b01, 2'b00};
  localparam logic [15:0] V_DEC   = {7'b0000000, 2'b00, 2'b00, 1'b0, 2'b11, 2'b00};
  localparam logic [15:0] V_MADDR = {7'b0000000, 2'b00, 2'b00, 1'b1, 2'b10, 2'b00};
  localparam logic [15:0] V_MRD   = {7'b0011000, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00};
  localparam logic [15:0] V_MWR   = {7'b0010100, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00};
  localparam logic [15:0] V_LDWB  = {7'b0000010, 2'b00, 2'b00, 1'b0, 2'b00, 2'b10};
  localparam logic [15:0] V_REX   = {7'b0000000, 2'b00, 2'b10, 1'b1, 2'b00, 2'b00};
  localparam logic [15:0] V_RWB   = {7'b0000000, 2'b00, 2'b00, 1'b0, 2'b00, 2'b11};
  localparam logic [15:0] V_BR    = {7'b0100000, 2'b01, 2'b01, 1'b1, 2'b00, 2'b00};
  localparam logic [15:0] V_JMP   = {7'b1000000, 2'b10, 2'b00, 1'b0, 2'b00, 2'b00};

  typedef struct {
    logic [15:0] v;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  function automatic logic [15:0] obs();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_sel, ir_wr,
            pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst};
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [15:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: one expected vector per cycle, sampled after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(obs(), e.v, e.tag);
      end
    end
  end

  // Driver: called at a falling edge in the load step. Model built from the requirements.
  task automatic issue(input logic [5:0] op, input bit alt_en, input logic [5:0] alt_op);
    int n;
    logic [5:0] op2;
    op2 = alt_en ? alt_op : op;
    opcode = op;
    push(V_FETCH, "R2 load step");
    push(V_DEC,   "R3 operand-read step");
    n = 2;
    case (op)
      6'h23, 6'h2B: begin
        push(V_MADDR, "R4 address step"); n++;
        if (op2 == 6'h23) begin
          push(V_MRD,  "R5 load read");       n++;
          push(V_LDWB, "R5 load write-back"); n++;
        end else if (op2 == 6'h2B) begin
          push(V_MWR,  "R6 store write");     n++;
        end
      end
      6'h00: begin
        push(V_REX, "R7 execute");    n++;
        push(V_RWB, "R7 write-back"); n++;
      end
      6'h04: begin push(V_BR,  "R8 branch"); n++; end
      6'h02: begin push(V_JMP, "R9 jump");   n++; end
      default: ;
    endcase
    repeat (2) @(negedge clk);
    if (alt_en) opcode = alt_op;
    repeat (n - 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(obs(), V_FETCH, "R1 vector during reset");
    @(negedge clk);
    rst_n = 1'b1;
    issue(6'h00, 1'b0, 6'h00);   // R7
    issue(6'h23, 1'b0, 6'h00);   // R5
    issue(6'h2B, 1'b0, 6'h00);   // R6
    issue(6'h04, 1'b0, 6'h00);   // R8
    issue(6'h02, 1'b0, 6'h00);   // R9
    issue(6'h3F, 1'b0, 6'h00);   // R3 unknown
    issue(6'h08, 1'b0, 6'h00);   // R3 unknown, R11 no writes
    issue(6'h23, 1'b1, 6'h3F);   // R4 fallback to load step
    issue(6'h23, 1'b1, 6'h2B);   // R4 second decision reads opcode
    issue(6'h00, 1'b1, 6'h23);   // R10 change during execute
    issue(6'h02, 1'b0, 6'h00);
    issue(6'h2B, 1'b0, 6'h00);
    issue(6'h23, 1'b0, 6'h00);
    #2;
    // R1: asynchronous reset in the middle of a load
    opcode = 6'h23;
    repeat (2) @(negedge clk);
    #1;
    check(obs(), V_MADDR, "R4 address step before reset");
    rst_n = 1'b0;
    #1;
    check(obs(), V_FETCH, "R1 asynchronous return");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(obs(), V_FETCH, "R1 first cycle after release");
    @(negedge clk);
    #1;
    check(obs(), V_DEC, "R2 load step followed by operand-read");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule